// File: doc/BRIEF.md
# Error-Record Register Access Trap Arbiter

This block decides, in a single combinational step, what happens when software tries to read or write one indirectly addressed error-record register. It looks at the privilege level of the requester (0 to 3), the direction of the access, and the configuration of the two upper levels:

- whether level 3 exists and level 2 is enabled;
- which execution state (32-bit or 64-bit) each of those levels uses;
- the error-trap and group-5 trap bits held at levels 2 and 3;
- a separate write-error-trap bit at level 3;
- two level-3 policy conditions: one that makes undefined win over traps, one that turns a level-3 trap into undefined;
- whether the processor is already in monitor mode.

The checks run as a fixed priority chain. An early stage can reject the access as undefined before any trap is considered. Level-2 traps follow, then level-3 traps. If nothing fires, the access goes ahead. The same level-3 error bit can therefore end as an early undefined result or as a later trap, depending on the priority condition.

The outcome leaves the block as a one-hot vector with a syndrome code beside it. A flag marks a level-2 trap that must be delivered in the 32-bit hypervisor form. The instruction decoder and the exception entry logic use these three outputs. The register contents and the selection of the record are held elsewhere.

Top module: `errrec_access_arbiter`

## Requirements
- R1: An access from privilege level 0 always produces undefined with syndrome 0, whatever the other inputs are.
- R2: At levels 1 and 2, if level 3 is present, the undefined-priority condition holds and the level-3 error-trap bit is set, the result is undefined. This holds in either level-3 execution state and takes precedence over every level-2 trap.
- R3: At level 1, if level 2 is enabled and either its group-5 trap bit or its error-trap bit is set, and R2 did not fire, the access traps to level 2 with syndrome 0x03. The hypervisor-form flag is 1 exactly when level 2 uses the 32-bit state.
- R4: At levels 1 and 2, if level 3 is present and uses the 64-bit state, its error-trap bit is set and no earlier rule fired: the access traps to level 3 with syndrome 0x03. If the undefine-instead condition holds, the result is undefined instead.
- R5: At levels 1 and 2, if level 3 is present and uses the 32-bit state, its error-trap bit is set and no earlier rule fired: the access traps to the monitor with syndrome 0. At level 1 this happens only when the processor is not in monitor mode; at level 2 it happens regardless of mode. If the undefine-instead condition holds, the result is undefined instead.
- R6: The level-3 write-error-trap bit acts only on writes, and only when level 3 is present and uses the 64-bit state. It gives the same results as the error-trap bit in the undefined-priority stage (R2) and in the trap stage (R4). On reads, or with a 32-bit level 3, it has no effect on the outputs.
- R7: At level 2, the level-2 enable, group-5 trap and error-trap inputs have no effect on the outputs.
- R8: At level 3, the access traps to the monitor (syndrome 0) when the processor is not in monitor mode and the level-3 error-trap bit is set. In every other case the access is allowed. All other configuration inputs are ignored.
- R9: When no rule fires, the access is allowed with syndrome 0.
- R10: The outcome vector is always one-hot. Its bits are: bit 0 allow, bit 1 undefined, bit 2 trap to level 2, bit 3 trap to level 3, bit 4 trap to monitor. The syndrome is nonzero only for bits 2 and 3. The hypervisor-form flag is 0 unless bit 2 is set.
- R11: At levels 1 and 2, when level 3 is absent, none of the level-3 bits or conditions affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_req | input | 1 | 1 = write access, 0 = read access |
| cur_lvl | input | 2 | Privilege level of the requester (0 to 3) |
| l3_present | input | 1 | Level 3 is implemented |
| l3_is_64 | input | 1 | Level 3 uses the 64-bit execution state |
| l2_enabled | input | 1 | Level 2 is enabled for the current context |
| l2_is_64 | input | 1 | Level 2 uses the 64-bit execution state |
| l3_err_trap | input | 1 | Level-3 error-record trap bit |
| l3_wr_err_trap | input | 1 | Level-3 write-only error-record trap bit |
| l2_grp5_trap | input | 1 | Level-2 trap bit for system-register group 5 |
| l2_err_trap | input | 1 | Level-2 error-record trap bit |
| undef_first | input | 1 | Undefined takes priority over traps at level 3 |
| undef_instead | input | 1 | A level-3 trap is replaced by undefined |
| in_monitor | input | 1 | Processor is currently in monitor mode |
| outcome | output | 5 | One-hot verdict (see R10) |
| syndrome | output | 8 | Trap syndrome code; 0x03 for level-2/level-3 traps |
| hyp_form | output | 1 | Level-2 trap uses the 32-bit hypervisor form |

## Verification
The embedded immediate assertions are evaluated only when every input is known. The bench drives all inputs from a single packed stimulus word, so each vector reaches the ports in one update and no mixture of old and new values is seen. The sweep includes combinations that real hardware never produces, such as level 3 marked 64-bit while level 3 is the requester. The requirements define the outputs for these combinations, so no assertion assumes they are absent. Each vector is compared with a behavioural priority chain in the bench, and the mismatch is attributed to the rule that decided the expected result.

// File: rtl/eaa_pkg.sv
package eaa_pkg;
  localparam int VERDICT_W = 5;
  localparam int SYN_W     = 8;

  typedef enum logic [2:0] {
    V_ALLOW    = 3'd0,
    V_UNDEF    = 3'd1,
    V_TRAP_L2  = 3'd2,
    V_TRAP_L3  = 3'd3,
    V_TRAP_MON = 3'd4
  } verdict_e;

  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_KERN = 2'd1,
    PL_HYP  = 2'd2,
    PL_MON  = 2'd3
  } plevel_e;

  function automatic logic [VERDICT_W-1:0] verdict_onehot(verdict_e v);
    logic [VERDICT_W-1:0] oh;
    oh = '0;
    oh[v] = 1'b1;
    return oh;
  endfunction

  // Write-only trap bit counts only for writes with a 64-bit level 3.
  function automatic logic wr_bit_live(logic wr, logic l3_64, logic wr_bit);
    return wr & l3_64 & wr_bit;
  endfunction

  // Where a fired level-3 check sends the access.
  function automatic verdict_e l3_destination(logic l3_64, logic undef_inst);
    if (undef_inst) return V_UNDEF;
    return l3_64 ? V_TRAP_L3 : V_TRAP_MON;
  endfunction
endpackage

// File: rtl/eaa_early_undef.sv
module eaa_early_undef
  import eaa_pkg::*;
(
  input  plevel_e lvl,
  input  logic    l3_present,
  input  logic    l3_is_64,
  input  logic    undef_first,
  input  logic    err_bit,
  input  logic    wr_req,
  input  logic    wr_err_bit,
  output logic    hit_err,
  output logic    hit_wr
);
  logic mid_level;
  logic gate;

  always_comb begin
    mid_level = (lvl == PL_KERN) || (lvl == PL_HYP);
    gate      = mid_level && l3_present && undef_first;
    hit_err   = gate && err_bit;
    hit_wr    = gate && wr_bit_live(wr_req, l3_is_64, wr_err_bit);
  end
endmodule

// File: rtl/eaa_l2_gate.sv
module eaa_l2_gate
  import eaa_pkg::*;
(
  input  plevel_e lvl,
  input  logic    l2_enabled,
  input  logic    l2_is_64,
  input  logic    grp5_bit,
  input  logic    err_bit,
  output logic    hit,
  output logic    hyp_kind
);
  always_comb begin
    hit      = (lvl == PL_KERN) && l2_enabled && (grp5_bit || err_bit);
    hyp_kind = hit && !l2_is_64;
  end
endmodule

// File: rtl/eaa_l3_gate.sv
module eaa_l3_gate
  import eaa_pkg::*;
(
  input  plevel_e  lvl,
  input  logic     l3_present,
  input  logic     l3_is_64,
  input  logic     err_bit,
  input  logic     wr_req,
  input  logic     wr_err_bit,
  input  logic     in_monitor,
  input  logic     undef_instead,
  output logic     hit,
  output verdict_e dest
);
  logic fire_64;
  logic fire_32;
  logic fire_top;

  always_comb begin
    fire_64  = 1'b0;
    fire_32  = 1'b0;
    fire_top = 1'b0;
    dest     = V_ALLOW;
    if (lvl == PL_MON) begin
      fire_top = !in_monitor && err_bit;
      dest     = V_TRAP_MON;
    end else if (lvl != PL_USER && l3_present) begin
      if (l3_is_64)
        fire_64 = err_bit || wr_bit_live(wr_req, 1'b1, wr_err_bit);
      else
        fire_32 = err_bit && ((lvl == PL_HYP) || !in_monitor);
      dest = l3_destination(l3_is_64, undef_instead);
    end
    hit = fire_64 || fire_32 || fire_top;
  end
endmodule

// File: rtl/errrec_access_arbiter.sv
module errrec_access_arbiter
  import eaa_pkg::*;
#(
  parameter int                  LVL_W    = 2,
  parameter int                  OUT_W    = VERDICT_W,
  parameter int                  CODE_W   = SYN_W,
  parameter logic [CODE_W-1:0]   TRAP_SYN = 8'h03
) (
  input  logic              wr_req,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic              l3_present,
  input  logic              l3_is_64,
  input  logic              l2_enabled,
  input  logic              l2_is_64,
  input  logic              l3_err_trap,
  input  logic              l3_wr_err_trap,
  input  logic              l2_grp5_trap,
  input  logic              l2_err_trap,
  input  logic              undef_first,
  input  logic              undef_instead,
  input  logic              in_monitor,
  output logic [OUT_W-1:0]  outcome,
  output logic [CODE_W-1:0] syndrome,
  output logic              hyp_form
);
  plevel_e  lvl;
  logic     early_err_hit;
  logic     early_wr_hit;
  logic     l2_hit;
  logic     l2_hyp;
  logic     l3_hit;
  verdict_e l3_dest;
  verdict_e verdict;

  assign lvl = plevel_e'(cur_lvl[1:0]);

  eaa_early_undef u_early (
    .lvl(lvl), .l3_present(l3_present), .l3_is_64(l3_is_64),
    .undef_first(undef_first), .err_bit(l3_err_trap), .wr_req(wr_req),
    .wr_err_bit(l3_wr_err_trap), .hit_err(early_err_hit), .hit_wr(early_wr_hit)
  );

  eaa_l2_gate u_l2 (
    .lvl(lvl), .l2_enabled(l2_enabled), .l2_is_64(l2_is_64),
    .grp5_bit(l2_grp5_trap), .err_bit(l2_err_trap),
    .hit(l2_hit), .hyp_kind(l2_hyp)
  );

  eaa_l3_gate u_l3 (
    .lvl(lvl), .l3_present(l3_present), .l3_is_64(l3_is_64),
    .err_bit(l3_err_trap), .wr_req(wr_req), .wr_err_bit(l3_wr_err_trap),
    .in_monitor(in_monitor), .undef_instead(undef_instead),
    .hit(l3_hit), .dest(l3_dest)
  );

  // Fixed priority: level 0, early undefined, level-2 trap, level-3 trap.
  always_comb begin
    if (lvl == PL_USER)                     verdict = V_UNDEF;
    else if (early_err_hit || early_wr_hit) verdict = V_UNDEF;
    else if (l2_hit)                        verdict = V_TRAP_L2;
    else if (l3_hit)                        verdict = l3_dest;
    else                                    verdict = V_ALLOW;
  end

  always_comb begin
    outcome  = verdict_onehot(verdict);
    syndrome = (verdict == V_TRAP_L2 || verdict == V_TRAP_L3) ? TRAP_SYN : '0;
    hyp_form = (verdict == V_TRAP_L2) && l2_hyp;
  end

  // Checks next to the decision logic.
  logic inputs_known;
  assign inputs_known = !$isunknown({wr_req, cur_lvl, l3_present, l3_is_64,
    l2_enabled, l2_is_64, l3_err_trap, l3_wr_err_trap, l2_grp5_trap,
    l2_err_trap, undef_first, undef_instead, in_monitor});

  always_comb begin
    if (inputs_known) begin
      assert_outcome_onehot_R10: assert ($onehot(outcome))
        else $error("outcome not one-hot");
      assert_user_undef_R1: assert (lvl != PL_USER || outcome[V_UNDEF])
        else $error("level 0 not undefined");
      assert_early_wins_R2: assert (!(early_err_hit || early_wr_hit) || outcome[V_UNDEF])
        else $error("early undefined overridden");
      assert_hyp_needs_l2_R3: assert (!hyp_form || outcome[V_TRAP_L2])
        else $error("hypervisor form without level-2 trap");
      assert_l2_skipped_R7: assert (lvl != PL_HYP || !outcome[V_TRAP_L2])
        else $error("level-2 trap at level 2");
      assert_top_level_R8: assert (lvl != PL_MON || outcome[V_ALLOW] || outcome[V_TRAP_MON])
        else $error("level 3 outcome out of range");
      assert_syndrome_R10: assert (syndrome == '0 || outcome[V_TRAP_L2] || outcome[V_TRAP_L3])
        else $error("syndrome without trap");
    end
  end
endmodule

// File: tb/errrec_access_arbiter_test.sv
module errrec_access_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] stim = '0;
  logic [4:0]  outcome;
  logic [7:0]  syndrome;
  logic        hyp_form;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  errrec_access_arbiter uut (
    .wr_req(stim[0]), .cur_lvl(stim[2:1]), .l3_present(stim[3]),
    .l3_is_64(stim[4]), .l2_enabled(stim[5]), .l2_is_64(stim[6]),
    .l3_err_trap(stim[7]), .l3_wr_err_trap(stim[8]), .l2_grp5_trap(stim[9]),
    .l2_err_trap(stim[10]), .undef_first(stim[11]), .undef_instead(stim[12]),
    .in_monitor(stim[13]), .outcome(outcome), .syndrome(syndrome),
    .hyp_form(hyp_form)
  );

  // Behavioural priority chain; result packed as {hyp, syndrome, outcome}.
  function automatic logic [13:0] expect_of(input logic [13:0] v, output string tag);
    int  lv;
    int  pick;
    bit  hyp;
    bit  wr, p3, w64, en2, h64, e3, we3, g5, e2, uf, ui, mon, wlive;
    wr = v[0]; lv = int'(v[2:1]); p3 = v[3]; w64 = v[4]; en2 = v[5];
    h64 = v[6]; e3 = v[7]; we3 = v[8]; g5 = v[9]; e2 = v[10];
    uf = v[11]; ui = v[12]; mon = v[13];
    wlive = wr && w64 && we3;
    hyp = 0;
    // pick: 0 allow, 1 undef, 2 trap L2, 3 trap L3, 4 monitor
    if (lv == 0) begin pick = 1; tag = "R1"; end
    else if (lv == 3) begin pick = (!mon && e3) ? 4 : 0; tag = "R8"; end
    else if (!p3 && !(lv == 1 && en2 && (g5 || e2))) begin pick = 0; tag = "R11"; end
    else if (p3 && uf && e3) begin pick = 1; tag = "R2"; end
    else if (p3 && uf && wlive) begin pick = 1; tag = "R6"; end
    else if (lv == 1 && en2 && (g5 || e2)) begin pick = 2; hyp = !h64; tag = "R3"; end
    else if (lv == 2 && en2 && (g5 || e2) && !(p3 && (e3 || wlive))) begin pick = 0; tag = "R7"; end
    else if (p3 && w64 && e3) begin pick = ui ? 1 : 3; tag = "R4"; end
    else if (p3 && wlive) begin pick = ui ? 1 : 3; tag = "R6"; end
    else if (p3 && !w64 && e3 && (lv == 2 || !mon)) begin pick = ui ? 1 : 4; tag = "R5"; end
    else begin pick = 0; tag = "R9"; end
    return {hyp, (pick == 2 || pick == 3) ? 8'h03 : 8'h00, 5'(1 << pick)};
  endfunction

  task automatic compare(input string tag, input logic [13:0] exp);
    logic [13:0] act;
    act = {hyp_form, syndrome, outcome};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s stim=%h actual=%h expected=%h", tag, stim, act, exp);
    end
  endtask

  initial begin
    string t;
    logic [13:0] e;
    repeat (3) @(posedge clk);
    // Reset state: all-zero inputs = read from level 0 (R1).
    @(negedge clk);
    e = expect_of(stim, t);
    compare("R1_reset", e);
    rst = 1'b0;
    for (int v = 0; v < (1 << 14); v++) begin
      @(posedge clk);
      #1 stim = 14'(v);
      @(negedge clk);
      e = expect_of(stim, t);
      compare(t, e);
      // R10 structural check independent of the model.
      n_cmp++;
      if (!$onehot(outcome) || (hyp_form && !outcome[2])) begin
        n_bad++;
        $display("FAIL R10 stim=%h actual=%b/%b expected=onehot", stim, outcome, hyp_form);
      end
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 60000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<60000", cycles);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    #20;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule